// File: doc/BRIEF.md
# Pulse Frequency Modulated Charge-Pump Controller

This block is the digital control for an on-chip switched-capacitor step-down converter. It regulates the load rail by pulse frequency modulation. On every clock edge it samples a clocked comparator that reports whether the load voltage has dropped under the reference. When the load is low, the controller delivers exactly one charge packet. It does so by driving two switch phases that never overlap, with a dead cycle after each. When the load is not low, nothing switches, and switching loss falls with the load.

The controller also picks the capacitor arrangement. Five arrangements give five no-load output ratios of the battery voltage. From an 8-bit target code and an 8-bit battery code, the controller selects the arrangement with the smallest no-load output that still lies strictly above the target. This keeps the linear conduction loss low. The selection is only re-evaluated while the converter is idle. A running count of delivered packets is available for monitoring.

Top module: `pfm_pump_ctrl`

## Requirements
- R1: While reset is asserted (rstN low), phaseOne, phaseTwo, gainSel and packetCount are all zero.
- R2: While idle, a low belowRef sampled at a clock edge leaves both phase outputs low in the following cycle, so no switching takes place.
- R3: A high belowRef sampled at an edge while idle starts one packet. In the four following cycles the outputs are: phaseOne alone high, then both low, then phaseTwo alone high, then both low. After that the block is idle again.
- R4: phaseOne and phaseTwo are never high in the same cycle. Each phase pulse lasts one cycle and is followed by a cycle with both low.
- R5: belowRef is ignored for the whole of a packet. A request seen only during a packet starts no further packet. A request held high produces one packet every five cycles (four packet cycles plus one idle sample cycle).
- R6: gainSel is the smallest code k in 0..4 for which target*den[k] < battery*num[k]. The no-load ratios num/den are code 0 = 1/4, code 1 = 1/3, code 2 = 1/2, code 3 = 2/3, code 4 = 3/4.
- R7: gainSel loads the value computed from the inputs present at an edge only when the block is idle at that edge. During a packet it holds its value.
- R8: packetCount rises by one at the edge that ends each packet, so the new count is visible in the first idle cycle after the packet. It is otherwise unchanged.
- R9: When no ratio exceeds the target (target*4 >= battery*3), gainSel is 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; also clocks the comparator sample |
| rstN | input | 1 | Active-low synchronous reset |
| belowRef | input | 1 | Comparator result, 1 when load voltage is below reference |
| targetCode | input | 8 | Target load voltage code |
| batteryCode | input | 8 | Battery voltage code |
| phaseOne | output | 1 | Enable for switch phase one |
| phaseTwo | output | 1 | Enable for switch phase two |
| gainSel | output | 3 | Selected capacitor arrangement, 0 to 4 |
| packetCount | output | 16 | Number of delivered charge packets, wraps |

## Verification
The assertions check on every cycle that the phases never overlap, that each phase pulse is followed by a dead cycle, and that phase two always follows phase one two cycles earlier. They also check that an idle cycle with no request produces no switching, that the gain code stays in range and holds during a packet, and that the counter moves only by one at packet end. The bench scenarios are needed for the rest. They show the exact phase pattern after a request, that a request arriving mid-packet does not start a second packet, and the steady five-cycle rate under a held request. They also check the gain codes at the ratio boundaries and the saturation to code 4.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
  localparam int unsigned NUM_GAIN = 5;
  localparam int unsigned GAIN_W   = $clog2(NUM_GAIN);
  localparam int unsigned RATIO_W  = 3;

  // no-load ratio of each capacitor arrangement, ascending
  localparam int unsigned GAIN_NUM [NUM_GAIN] = '{1, 1, 1, 2, 3};
  localparam int unsigned GAIN_DEN [NUM_GAIN] = '{4, 3, 2, 3, 4};

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PH1   = 3'd1,
    ST_DEAD1 = 3'd2,
    ST_PH2   = 3'd3,
    ST_DEAD2 = 3'd4
  } pumpState_e;

  typedef struct packed {
    logic gainLoad;
    logic packetDone;
  } pumpStrobe_t;
endpackage

// File: rtl/pfm_seq_ctrl.sv
module pfm_seq_ctrl
  import pfm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        belowRef,
  output logic        phaseOne,
  output logic        phaseTwo,
  output pumpStrobe_t strobe
);

  pumpState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (belowRef) stateNext = ST_PH1;
      ST_PH1:   stateNext = ST_DEAD1;
      ST_DEAD1: stateNext = ST_PH2;
      ST_PH2:   stateNext = ST_DEAD2;
      ST_DEAD2: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign phaseOne          = (state == ST_PH1);
  assign phaseTwo          = (state == ST_PH2);
  assign strobe.gainLoad   = (state == ST_IDLE);
  assign strobe.packetDone = (state == ST_DEAD2);

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(phaseOne && phaseTwo)); // R4
  AST_DEAD_AFTER_P1: assert property (@(posedge clk) disable iff (!rstN)
    phaseOne |=> (!phaseOne && !phaseTwo)); // R4
  AST_DEAD_AFTER_P2: assert property (@(posedge clk) disable iff (!rstN)
    phaseTwo |=> (!phaseOne && !phaseTwo)); // R4
  AST_P2_FOLLOWS_P1: assert property (@(posedge clk) disable iff (!rstN)
    phaseOne |=> ##1 phaseTwo); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.gainLoad && !belowRef) |=> (!phaseOne && !phaseTwo)); // R2

endmodule

// File: rtl/pfm_gain_dp.sv
module pfm_gain_dp
  import pfm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  pumpStrobe_t       strobe,
  input  logic [DATA_W-1:0] targetCode,
  input  logic [DATA_W-1:0] batteryCode,
  output logic [GAIN_W-1:0] gainSel,
  output logic [CNT_W-1:0]  packetCount
);

  localparam int unsigned PROD_W = DATA_W + RATIO_W;

  logic [NUM_GAIN-1:0] fits;
  logic [GAIN_W-1:0]   gainPick;

  for (genvar k = 0; k < NUM_GAIN; k++) begin : g_ratio
    logic [PROD_W-1:0] lhs, rhs;
    assign lhs = PROD_W'(targetCode)  * PROD_W'(GAIN_DEN[k]);
    assign rhs = PROD_W'(batteryCode) * PROD_W'(GAIN_NUM[k]);
    assign fits[k] = (lhs < rhs);
  end

  always_comb begin
    gainPick = GAIN_W'(NUM_GAIN - 1);
    for (int k = NUM_GAIN - 1; k >= 0; k--) begin
      if (fits[k]) gainPick = GAIN_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gainSel     <= '0;
      packetCount <= '0;
    end else begin
      if (strobe.gainLoad)   gainSel     <= gainPick;
      if (strobe.packetDone) packetCount <= packetCount + 1'b1;
    end
  end

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    gainSel < GAIN_W'(NUM_GAIN)); // R6
  AST_GAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.gainLoad |=> $stable(gainSel)); // R7
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.packetDone |=> (packetCount == $past(packetCount) + 1'b1)); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.packetDone |=> $stable(packetCount)); // R8

endmodule

// File: rtl/pfm_pump_ctrl.sv
module pfm_pump_ctrl
  import pfm_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowRef,
  input  logic [DATA_W-1:0] targetCode,
  input  logic [DATA_W-1:0] batteryCode,
  output logic              phaseOne,
  output logic              phaseTwo,
  output logic [GAIN_W-1:0] gainSel,
  output logic [CNT_W-1:0]  packetCount
);

  pumpStrobe_t strobe;

  pfm_seq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .belowRef (belowRef),
    .phaseOne (phaseOne),
    .phaseTwo (phaseTwo),
    .strobe   (strobe)
  );

  pfm_gain_dp #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .targetCode  (targetCode),
    .batteryCode (batteryCode),
    .gainSel     (gainSel),
    .packetCount (packetCount)
  );

endmodule

// File: tb/pfm_pump_ctrl_test.sv
module pfm_pump_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        belowRef = 1'b0;
  logic [7:0]  targetCode = 8'd0;
  logic [7:0]  batteryCode = 8'd0;
  logic        phaseOne, phaseTwo;
  logic [2:0]  gainSel;
  logic [15:0] packetCount;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  pfm_pump_ctrl uut (
    .clk(clk), .rstN(rstN), .belowRef(belowRef),
    .targetCode(targetCode), .batteryCode(batteryCode),
    .phaseOne(phaseOne), .phaseTwo(phaseTwo),
    .gainSel(gainSel), .packetCount(packetCount)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic checkEq(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkPhases(input string req, input int e1, input int e2);
    checkEq({req, " phaseOne"}, int'(phaseOne), e1);
    checkEq({req, " phaseTwo"}, int'(phaseTwo), e2);
  endtask

  task automatic tReset();
    @(negedge clk);
    checkPhases("R1 reset", 0, 0);
    checkEq("R1 reset gainSel", int'(gainSel), 0);
    checkEq("R1 reset packetCount", int'(packetCount), 0);
    rstN = 1'b1;
  endtask

  task automatic tIdle();
    int c0 = int'(packetCount);
    belowRef = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      checkPhases("R2 idle", 0, 0);
    end
    checkEq("R2 idle packetCount", int'(packetCount), c0);
  endtask

  // one request; busyLevel is belowRef during the packet
  task automatic tPacket(input logic busyLevel, input string req);
    int c0 = int'(packetCount);
    belowRef = 1'b1;
    @(negedge clk); belowRef = busyLevel;
    checkPhases({req, " R3 ph1"}, 1, 0);
    @(negedge clk);
    checkPhases({req, " R4 dead1"}, 0, 0);
    @(negedge clk);
    checkPhases({req, " R3 ph2"}, 0, 1);
    @(negedge clk); belowRef = 1'b0;
    checkPhases({req, " R4 dead2"}, 0, 0);
    checkEq({req, " R8 count before end"}, int'(packetCount), c0);
    @(negedge clk);
    checkPhases({req, " R3 back idle"}, 0, 0);
    checkEq({req, " R8 count after"}, int'(packetCount), c0 + 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      checkPhases({req, " R5 no extra packet"}, 0, 0);
    end
    checkEq({req, " R5 count stable"}, int'(packetCount), c0 + 1);
  endtask

  task automatic tHeld();
    int c0 = int'(packetCount);
    belowRef = 1'b1;
    for (int k = 1; k <= 15; k++) begin
      @(negedge clk);
      if (k == 15) belowRef = 1'b0;
      case ((k - 1) % 5)
        0: checkPhases("R5 held ph1", 1, 0);
        2: checkPhases("R5 held ph2", 0, 1);
        4: checkEq("R5 held count", int'(packetCount), c0 + k / 5);
        default: checkPhases("R4 held dead", 0, 0);
      endcase
    end
    @(negedge clk);
    checkPhases("R5 held released", 0, 0);
    checkEq("R5 held total", int'(packetCount), c0 + 3);
  endtask

  task automatic tGain(input int tgt, input int bat, input int exp, input string req);
    targetCode = 8'(tgt); batteryCode = 8'(bat);
    @(negedge clk);
    checkEq(req, int'(gainSel), exp);
  endtask

  task automatic tGainHold();
    targetCode = 8'd50; batteryCode = 8'd240;
    @(negedge clk);
    belowRef = 1'b1;
    @(negedge clk); belowRef = 1'b0;
    targetCode = 8'd200;
    checkEq("R7 hold ph1", int'(gainSel), 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checkEq("R7 hold in packet", int'(gainSel), 0);
    end
    @(negedge clk);
    checkEq("R7 hold first idle", int'(gainSel), 0);
    @(negedge clk);
    checkEq("R7 update when idle", int'(gainSel), 4);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    tReset();
    tIdle();
    tPacket(1'b0, "single");
    tPacket(1'b1, "busy request");
    tHeld();
    tIdle();
    tGain(50, 240, 0, "R6 quarter");
    tGain(60, 240, 1, "R6 boundary third");
    tGain(80, 240, 2, "R6 half");
    tGain(120, 240, 3, "R6 two thirds");
    tGain(159, 240, 3, "R6 below three quarters");
    tGain(160, 240, 4, "R6 three quarters");
    tGain(200, 240, 4, "R9 saturate");
    tGain(0, 0, 4, "R9 zero battery");
    tGainHold();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule